// File: doc/BRIEF.md
# Bitstream Frame Alignment Tracker

This block watches a serial bitstream that arrives one bit per enable pulse and is organised in frames of fixed length (512 bits by default). The first bit of every frame belongs to a repeating alignment word (8 bits by default). The block does not know where the frames start. It tests every bit position within a frame at once, as the bits arrive. It declares frame lock when one position has carried the alignment word, in its proper cyclic order, three times running.

Once in lock, the block predicts each framing bit and compares it with the received bit. A single wrong framing bit opens a verification window over the next four framing bits. A second miss inside that window drops the lock, sets a sticky loss flag, pulses an active-low error output and restarts the search. If the window closes clean, the first miss is treated as a random bit error. A bypass input makes the lock flag read as locked for streams that carry no framing.

Top module: `frame_align_tracker`

## Requirements
- R1: While reset is held and immediately after it, lock_o, mark_o and loss_o are 0 and err_n_o is 1.
- R2: Successive frames carry the alignment word MSB first, cyclically (with the default 8'b00011011: 0,0,0,1,1,0,1,1,0,...), and the sequence may start at any of its rotations. lock_o rises in the cycle after the edge that takes in the 24th consecutive correct framing bit at one position, and not after the 23rd.
- R3: A new search only uses bits received since that search began. After a loss, lock at a new frame position is declared on its 24th framing bit received after the loss, and not on its 23rd.
- R4: While locked, mark_o is high for exactly the one cycle after each edge that takes in a framing bit.
- R5: One wrong framing bit followed by four correct ones leaves lock_o at 1, loss_o at 0 and err_n_o at 1. A later miss opens a fresh window.
- R6: A second wrong framing bit within the four framing bits after a first miss (the fourth included) clears lock_o, sets loss_o and drives err_n_o low in the cycle after the edge that takes in that bit.
- R7: err_n_o is low for exactly one clock per declared loss.
- R8: loss_o stays at 1 until the next lock is declared, and is cleared then.
- R9: While bypass is high, lock_o reads 1 at once and mark_o stays 0. After bypass is released, lock_o is 0 and the search starts again.
- R10: Cycles with bit_en low take in no bit, do not advance the frame position and produce no mark.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | High when bit_in carries a new stream bit |
| bit_in | input | 1 | Serial stream bit |
| bypass | input | 1 | Ignore framing; lock_o forced to 1 |
| lock_o | output | 1 | Frame lock flag |
| mark_o | output | 1 | One-cycle pulse after a framing bit is taken in while locked |
| loss_o | output | 1 | Sticky loss-of-alignment status |
| err_n_o | output | 1 | Active-low one-cycle pulse on each declared loss |

## Verification
Every registered result (lock_o, mark_o, loss_o, err_n_o) is due in the cycle directly after the clock edge that consumes the deciding bit, with no further pipeline stage. The bench drives each bit on a falling edge and reads the outputs on the next falling edge, so each check lands exactly one register stage after its stimulus. The lock edge is checked on both sides: still 0 after the 23rd framing bit, and 1 after the 24th. The bypass effect on lock_o is combinational, so it is read within the same cycle in which bypass changes.

// File: rtl/fat_pkg.sv
// Shared types for the frame alignment tracker.
// Assumes: nothing beyond IEEE 1800-2017.
package fat_pkg;
    typedef enum logic [1:0] {
        TRK_HUNT   = 2'd0,
        TRK_LOCK   = 2'd1,
        TRK_VERIFY = 2'd2
    } trk_state_t;
endpackage

// File: rtl/fat_bit_position.sv
// Bit position counter within a frame.
// Advances once per accepted stream bit and wraps after FRAME_BITS bits.
// Assumes: FRAME_BITS >= 2.
module fat_bit_position #(
    parameter int FRAME_BITS = 512,
    localparam int PW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    output logic [PW-1:0] pos
);
    localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

    // Count accepted bits modulo the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (bit_en)
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
    end

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST); // R10

    AST_POS_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(pos)); // R10
endmodule

// File: rtl/fat_phase_search.sv
// Parallel phase search.
// Keeps, for each bit position in a frame, the last REPEATS*PAT_LEN bits seen
// there (newest at bit 0), and flags a hit when the updated history is periodic
// with period PAT_LEN and its newest PAT_LEN bits are a rotation of PATTERN.
// A hit is only allowed once the current search has taken in enough bits that
// every position holds history gathered since the search began.
// Assumes: PATTERN has no period shorter than PAT_LEN.
module fat_phase_search #(
    parameter int                FRAME_BITS = 512,
    parameter int                PAT_LEN    = 8,
    parameter logic [PAT_LEN-1:0] PATTERN   = 8'b00011011,
    parameter int                REPEATS    = 3,
    localparam int PW    = $clog2(FRAME_BITS),
    localparam int HW    = REPEATS * PAT_LEN,
    localparam int LIMIT = (HW - 1) * FRAME_BITS,
    localparam int CW    = $clog2(LIMIT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic               bit_in,
    input  logic [PW-1:0]      pos,
    input  logic               hunting,
    output logic               hit,
    output logic [PAT_LEN-1:0] seed
);
    localparam logic [2*PAT_LEN-1:0] PP = {PATTERN, PATTERN};

    logic [HW-1:0]      hist [FRAME_BITS];
    logic [HW-1:0]      nxt;
    logic [CW-1:0]      fill_cnt;
    logic [PAT_LEN-1:0] rot_hit;
    logic               periodic;
    logic               filled;

    // Updated history word for the current position.
    always_comb nxt = {hist[pos][HW-2:0], bit_in};

    // Store the updated history of every accepted bit.
    always_ff @(posedge clk) begin
        if (bit_en)
            hist[pos] <= nxt;
    end

    // Count bits since the search began; cleared while not hunting.
    always_ff @(posedge clk) begin
        if (!rst_n || !hunting)
            fill_cnt <= '0;
        else if (bit_en && fill_cnt != CW'(LIMIT))
            fill_cnt <= fill_cnt + 1'b1;
    end

    // One comparator per rotation of the alignment word.
    for (genvar k = 0; k < PAT_LEN; k++) begin : g_rot
        assign rot_hit[k] = (nxt[PAT_LEN-1:0] == PP[k +: PAT_LEN]);
    end

    // Qualify the match.
    always_comb begin
        periodic = (nxt[HW-1:PAT_LEN] == nxt[HW-PAT_LEN-1:0]);
        filled   = (fill_cnt == CW'(LIMIT));
        hit      = hunting && bit_en && filled && periodic && (rot_hit != '0);
        seed     = nxt[PAT_LEN-1:0];
    end

    AST_ONE_ROTATION: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $onehot0(rot_hit)); // R2

    AST_FILL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !hunting |=> fill_cnt == '0); // R3
endmodule

// File: rtl/fat_lock_fsm.sv
// Lock keeper.
// Takes the first search hit as lock, then predicts every framing bit from a
// ring holding one alignment period, and runs the miss-verification window.
// Assumes: hit only rises on an accepted bit.
module fat_lock_fsm #(
    parameter int FRAME_BITS  = 512,
    parameter int PAT_LEN     = 8,
    parameter int VERIFY_BITS = 4,
    localparam int PW = $clog2(FRAME_BITS),
    localparam int VW = $clog2(VERIFY_BITS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic               bit_in,
    input  logic               bypass,
    input  logic [PW-1:0]      pos,
    input  logic               hit,
    input  logic [PAT_LEN-1:0] seed,
    output logic               hunting,
    output logic               locked,
    output logic               mark,
    output logic               loss,
    output logic               err_n
);
    import fat_pkg::*;

    trk_state_t         state;
    logic [PW-1:0]      phase;
    logic [PAT_LEN-1:0] ring;
    logic [VW-1:0]      vcnt;
    logic               at_frame;
    logic               miss;

    // Framing bit present now, and whether it disagrees with the prediction.
    always_comb begin
        at_frame = bit_en && (pos == phase);
        miss     = (bit_in != ring[PAT_LEN-1]);
        hunting  = (state == TRK_HUNT) && !bypass;
        locked   = (state != TRK_HUNT);
    end

    // Lock state, prediction ring and status outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TRK_HUNT;
            phase <= '0;
            ring  <= '0;
            vcnt  <= '0;
            mark  <= 1'b0;
            loss  <= 1'b0;
            err_n <= 1'b1;
        end else begin
            mark  <= 1'b0;
            err_n <= 1'b1;
            if (bypass) begin
                state <= TRK_HUNT;
            end else begin
                case (state)
                    TRK_HUNT: if (hit) begin
                        state <= TRK_LOCK;
                        phase <= pos;
                        ring  <= seed;
                        loss  <= 1'b0;
                    end
                    TRK_LOCK: if (at_frame) begin
                        mark <= 1'b1;
                        ring <= {ring[PAT_LEN-2:0], ring[PAT_LEN-1]};
                        if (miss) begin
                            state <= TRK_VERIFY;
                            vcnt  <= VW'(VERIFY_BITS);
                        end
                    end
                    TRK_VERIFY: if (at_frame) begin
                        mark <= 1'b1;
                        ring <= {ring[PAT_LEN-2:0], ring[PAT_LEN-1]};
                        if (miss) begin
                            state <= TRK_HUNT;
                            loss  <= 1'b1;
                            err_n <= 1'b0;
                        end else if (vcnt == VW'(1)) begin
                            state <= TRK_LOCK;
                        end else begin
                            vcnt <= vcnt - 1'b1;
                        end
                    end
                    default: state <= TRK_HUNT;
                endcase
            end
        end
    end

    AST_MARK_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        mark |-> $past(state) != TRK_HUNT); // R4

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !err_n |=> err_n); // R7

    AST_ERR_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |-> (state == TRK_HUNT) && loss); // R6

    AST_LOCK_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == TRK_HUNT && state != TRK_HUNT) |-> $past(bit_en)); // R10

    AST_PHASE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != TRK_HUNT && state != TRK_HUNT) |-> $stable(phase)); // R4

    AST_VERIFY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        state == TRK_VERIFY |-> (vcnt >= VW'(1) && vcnt <= VW'(VERIFY_BITS))); // R5
endmodule

// File: rtl/frame_align_tracker.sv
// Frame alignment tracker, top level.
// Finds the framing-bit position of a serial stream by parallel phase search,
// holds lock with a miss-verification window and reports loss.
// Assumes: one stream bit per cycle at most, qualified by bit_en.
module frame_align_tracker #(
    parameter int                FRAME_BITS  = 512,
    parameter int                PAT_LEN     = 8,
    parameter logic [PAT_LEN-1:0] PATTERN    = 8'b00011011,
    parameter int                REPEATS     = 3,
    parameter int                VERIFY_BITS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    input  logic bypass,
    output logic lock_o,
    output logic mark_o,
    output logic loss_o,
    output logic err_n_o
);
    localparam int PW = $clog2(FRAME_BITS);

    logic [PW-1:0]      pos;
    logic               hunting;
    logic               hit;
    logic [PAT_LEN-1:0] seed;
    logic               locked;

    fat_bit_position #(.FRAME_BITS(FRAME_BITS)) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .pos    (pos)
    );

    fat_phase_search #(
        .FRAME_BITS (FRAME_BITS),
        .PAT_LEN    (PAT_LEN),
        .PATTERN    (PATTERN),
        .REPEATS    (REPEATS)
    ) u_search (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .bit_in  (bit_in),
        .pos     (pos),
        .hunting (hunting),
        .hit     (hit),
        .seed    (seed)
    );

    fat_lock_fsm #(
        .FRAME_BITS  (FRAME_BITS),
        .PAT_LEN     (PAT_LEN),
        .VERIFY_BITS (VERIFY_BITS)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .bit_in  (bit_in),
        .bypass  (bypass),
        .pos     (pos),
        .hit     (hit),
        .seed    (seed),
        .hunting (hunting),
        .locked  (locked),
        .mark    (mark_o),
        .loss    (loss_o),
        .err_n   (err_n_o)
    );

    // Bypass forces the lock flag on.
    always_comb lock_o = locked || bypass;

    AST_BYPASS_NO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bypass) |-> !mark_o); // R9
endmodule

// File: tb/test_frame_align_tracker.sv
module test_frame_align_tracker;
    localparam int             FRAME = 512;
    localparam int             PLEN  = 8;
    localparam logic [PLEN-1:0] PAT  = 8'b00011011;

    logic clk = 1'b0;
    logic rst_n, bit_en, bit_in, bypass;
    logic lock_o, mark_o, loss_o, err_n_o;

    int n_cmp = 0;
    int n_bad = 0;
    int g = 0;
    int base = 0;
    int k = 0;
    bit framing_on = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    frame_align_tracker i_frame_align_tracker (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .bit_in  (bit_in),
        .bypass  (bypass),
        .lock_o  (lock_o),
        .mark_o  (mark_o),
        .loss_o  (loss_o),
        .err_n_o (err_n_o)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        bit_in = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        g++;
    endtask

    task automatic idle();
        bit_en = 1'b0;
        bit_in = ~bit_in;
        @(negedge clk);
    endtask

    function automatic bit frame_next();
        return framing_on && (g >= base) && (((g - base) % FRAME) == 0);
    endfunction

    task automatic skip_data(input bit gaps);
        int n = 0;
        while (!frame_next()) begin
            if (gaps && (n % 9 == 4)) idle();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send_bit(lfsr[0]);
            n++;
        end
    endtask

    task automatic send_frame(input bit flip);
        send_bit(PAT[PLEN - 1 - (k % PLEN)] ^ flip);
        k++;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0; bypass = 1'b0;
        repeat (5) @(negedge clk);
        check("R1", "lock in reset", lock_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "lock", lock_o, 1'b0);
        check("R1", "mark", mark_o, 1'b0);
        check("R1", "loss", loss_o, 1'b0);
        check("R1", "err_n", err_n_o, 1'b1);
    endtask

    // R2, R10: acquisition from a mid-sequence rotation with idle gaps
    task automatic t_acquire();
        framing_on = 1'b1; base = 100; k = 3;
        for (int i = 1; i <= 24; i++) begin
            skip_data(1'b1);
            send_frame(1'b0);
            if (i == 23) check("R2", "lock after 23rd framing bit", lock_o, 1'b0);
        end
        check("R2", "lock after 24th framing bit", lock_o, 1'b1);
        check("R10", "gaps do not shift lock timing", loss_o, 1'b0);
    endtask

    // R4, R10: mark pulse timing, idle cycles ignored
    task automatic t_mark();
        skip_data(1'b0);
        idle(); idle(); idle();
        check("R10", "no mark on idle cycles", mark_o, 1'b0);
        check("R10", "lock held over idle cycles", lock_o, 1'b1);
        send_frame(1'b0);
        check("R4", "mark after framing bit", mark_o, 1'b1);
        send_bit(1'b0);
        check("R4", "mark lasts one cycle", mark_o, 1'b0);
    endtask

    // R5, R6, R7, R8: random error tolerated, then loss on 4th follow-up
    task automatic t_errors();
        skip_data(1'b0);
        send_frame(1'b1);
        check("R5", "lock after first miss", lock_o, 1'b1);
        for (int i = 0; i < 4; i++) begin
            skip_data(1'b0);
            send_frame(1'b0);
            check("R5", "err_n in window", err_n_o, 1'b1);
        end
        check("R5", "lock kept", lock_o, 1'b1);
        check("R5", "loss clear", loss_o, 1'b0);
        skip_data(1'b0);
        send_frame(1'b1);
        check("R5", "new window opens", lock_o, 1'b1);
        for (int i = 0; i < 3; i++) begin
            skip_data(1'b0);
            send_frame(1'b0);
        end
        check("R6", "lock before last follow-up", lock_o, 1'b1);
        skip_data(1'b0);
        send_frame(1'b1);
        check("R6", "lock dropped", lock_o, 1'b0);
        check("R6", "loss set", loss_o, 1'b1);
        check("R6", "err_n low", err_n_o, 1'b0);
        send_bit(1'b0);
        check("R7", "err_n back high", err_n_o, 1'b1);
        check("R8", "loss sticky", loss_o, 1'b1);
    endtask

    // R3, R8: relock at a new position after loss
    task automatic t_relock();
        base = g + 37; k = 5;
        for (int i = 1; i <= 24; i++) begin
            skip_data(1'b0);
            send_frame(1'b0);
            if (i == 23) begin
                check("R3", "no relock on 23rd", lock_o, 1'b0);
                check("R8", "loss held while hunting", loss_o, 1'b1);
            end
        end
        check("R3", "relock on 24th", lock_o, 1'b1);
        check("R8", "loss cleared on lock", loss_o, 1'b0);
    endtask

    // R9: bypass forces lock and suppresses marks
    task automatic t_bypass();
        bit seen = 1'b0;
        framing_on = 1'b0;
        bypass = 1'b1;
        #1;
        check("R9", "lock forced at once", lock_o, 1'b1);
        @(negedge clk);
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send_bit(lfsr[0]);
            if (mark_o) seen = 1'b1;
        end
        check("R9", "no mark in bypass", seen, 1'b0);
        check("R9", "lock still forced", lock_o, 1'b1);
        bypass = 1'b0;
        @(negedge clk);
        check("R9", "search restarted after bypass", lock_o, 1'b0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_acquire();
        t_mark();
        t_errors();
        t_relock();
        t_bypass();
        summary();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule